// File: doc/BRIEF.md
# Dual-Bank Write Completion Status Reporter

This block models the status path of a flash array split into two independently writable banks. Each bank runs its own internally timed program or erase cycle. The cycle starts from a one-cycle start pulse, and the pulse carries an operation type and the data word that was loaded last. While a bank is busy, a read of that bank returns a status word and no array data. In that word the polled data bit is inverted and a toggle bit flips on every read. A read of a bank that is not busy passes the external array data through unchanged, even while the other bank is busy.

An open-drain style indication is asserted while any bank has a cycle in progress. The surrounding logic uses it to pull the shared ready/busy line low. When it is deasserted the line is left floating. Cycle lengths are parameters given in clock counts. The defaults match the nominal durations at a 100 MHz clock: 20 us for a program, 25 ms for a sector or block erase and 100 ms for a whole-bank erase. A test setup can override them with short values. A host that sees a status match at the moment a cycle completes should read the same location twice more to confirm it. The block supports this by keeping the data stable after completion.

Top module: `flash_wstat`

## Requirements
- R1: During and right after reset, `rd_data_o` is all zeros, `rb_low_o` is 0 and both banks are idle.
- R2: A start pulse to an idle bank begins a cycle whose length depends on `op_i`. The encodings are 0 = word program (`PROG_CYC`), 1 = sector erase (`SECT_CYC`), 2 = block erase (`BLK_CYC`) and 3 = whole-bank erase (`BANK_CYC`). The bank reports busy for exactly that many clock cycles after the start edge.
- R3: The toggle bit (bit 6 of the status word) is 0 on the first status read after a start. Each later read strobe to the same busy bank inverts it.
- R4: A read of a busy bank returns the word latched at start with bit 7 inverted and bit 6 replaced by the toggle bit. All other bits are unchanged.
- R5: `rb_low_o` is 1 while any bank is busy and 0 otherwise.
- R6: A start pulse to a busy bank is ignored. It does not restart or lengthen the running cycle and does not change the latched word or the toggle bit.
- R7: A read of an idle bank returns `arr_data_i` as it was at the strobe edge. This also holds while the other bank is busy.
- R8: Once a cycle has completed, repeated reads of that bank return array data, and the toggle bit no longer changes.
- R9: `rd_data_o` is registered. It updates on the clock edge that samples `rd_stb_i` and holds its value while no strobe is present.
- R10: The two banks run independently and can be busy at the same time. `rb_low_o` stays asserted until the later of the two cycles ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | NBANK | One-cycle start pulse per bank |
| op_i | input | 2 | Operation type for the start pulse |
| word_i | input | DW | Last loaded data word, latched on an accepted start |
| rd_stb_i | input | 1 | Read strobe |
| rd_bank_i | input | BSW | Bank addressed by the read |
| arr_data_i | input | DW | Array data for reads of an idle bank |
| rd_data_o | output | DW | Registered read result |
| rb_low_o | output | 1 | 1 = pull the ready/busy line low |

## Verification
The bound checker covers the following on every cycle:
- an accepted start makes the bank busy;
- a running cycle cannot be cut short;
- a start to a busy bank leaves its latched state alone;
- each status read flips the toggle bit, and the bit stays still while the bank is idle;
- the read register returns either the status word or the array data, as appropriate;
- the ready/busy indication rises only after an accepted start.

The bench scenarios cover what needs a whole cycle to show:
- exact cycle lengths for each operation code;
- the toggle sequence restarting at 0 after a new start;
- the pair of confirming reads after completion;
- the ready/busy indication spanning two overlapping cycles of different lengths.

// File: rtl/flash_wstat_pkg.sv
package flash_wstat_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_BANK = 2'd3
  } wop_e;

  // bit positions decoded by the host's polling routine
  localparam int unsigned POLL_BIT = 7;
  localparam int unsigned TOG_BIT  = 6;

  function automatic int unsigned op_cycles(input wop_e op,
                                            input int unsigned c_prog,
                                            input int unsigned c_sect,
                                            input int unsigned c_blk,
                                            input int unsigned c_bank);
    case (op)
      OP_PROG: return c_prog;
      OP_SECT: return c_sect;
      OP_BLK:  return c_blk;
      default: return c_bank;
    endcase
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/flash_wstat_timer.sv
module flash_wstat_timer
  import flash_wstat_pkg::*;
#(
  parameter int unsigned DW       = 16,
  parameter int unsigned CW       = 8,
  parameter int unsigned PROG_CYC = 20,
  parameter int unsigned SECT_CYC = 50,
  parameter int unsigned BLK_CYC  = 50,
  parameter int unsigned BANK_CYC = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  wop_e          op_i,
  input  logic [DW-1:0] word_i,
  input  logic          rd_hit_i,
  output logic          busy_o,
  output logic          accept_o,
  output logic          done_o,
  output logic          tog_o,
  output logic [DW-1:0] stat_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] load_w;
  logic [DW-1:0] word_q;
  logic          tog_q;

  function automatic logic [DW-1:0] poll_word(input logic [DW-1:0] w, input logic t);
    logic [DW-1:0] r;
    r           = w;
    r[POLL_BIT] = ~w[POLL_BIT];
    r[TOG_BIT]  = t;
    return r;
  endfunction

  assign load_w   = CW'(op_cycles(op_i, PROG_CYC, SECT_CYC, BLK_CYC, BANK_CYC));
  assign busy_o   = (cnt_q != '0);
  assign accept_o = start_i & ~busy_o;
  assign done_o   = busy_o && (cnt_q == CW'(1));
  assign tog_o    = tog_q;
  assign stat_o   = poll_word(word_q, tog_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      word_q <= '0;
      tog_q  <= 1'b0;
    end else if (accept_o) begin
      cnt_q  <= load_w;
      word_q <= word_i;
      tog_q  <= 1'b0;
    end else begin
      if (busy_o) cnt_q <= cnt_q - CW'(1);
      if (busy_o && rd_hit_i) tog_q <= ~tog_q;
    end
  end

endmodule

// File: rtl/flash_wstat_rdport.sv
module flash_wstat_rdport #(
  parameter int unsigned NBANK = 2,
  parameter int unsigned DW    = 16,
  parameter int unsigned BSW   = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_stb_i,
  input  logic [BSW-1:0]            rd_bank_i,
  input  logic [NBANK-1:0]          busy_i,
  input  logic [NBANK-1:0][DW-1:0]  stat_i,
  input  logic [DW-1:0]             arr_i,
  output logic [NBANK-1:0]          hit_o,
  output logic [DW-1:0]             rd_data_o
);

  logic          sel_busy;
  logic [DW-1:0] sel_stat;

  for (genvar b = 0; b < NBANK; b++) begin : g_hit
    assign hit_o[b] = rd_stb_i && (rd_bank_i == BSW'(b));
  end

  always_comb begin
    sel_busy = 1'b0;
    sel_stat = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (rd_bank_i == BSW'(b)) begin
        sel_busy = busy_i[b];
        sel_stat = stat_i[b];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        rd_data_o <= '0;
    else if (rd_stb_i) rd_data_o <= sel_busy ? sel_stat : arr_i;
  end

endmodule

// File: rtl/flash_wstat.sv
module flash_wstat
  import flash_wstat_pkg::*;
#(
  parameter int unsigned NBANK    = 2,
  parameter int unsigned DW       = 16,
  parameter int unsigned PROG_CYC = 2000,
  parameter int unsigned SECT_CYC = 2500000,
  parameter int unsigned BLK_CYC  = 2500000,
  parameter int unsigned BANK_CYC = 10000000,
  localparam int unsigned BSW     = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBANK-1:0] start_i,
  input  logic [1:0]       op_i,
  input  logic [DW-1:0]    word_i,
  input  logic             rd_stb_i,
  input  logic [BSW-1:0]   rd_bank_i,
  input  logic [DW-1:0]    arr_data_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             rb_low_o
);

  localparam int unsigned MAXC = max4(PROG_CYC, SECT_CYC, BLK_CYC, BANK_CYC);
  localparam int unsigned CW   = $clog2(MAXC + 1);

  // named internal events, observed by the bound checker
  logic [NBANK-1:0]         busy_w;
  logic [NBANK-1:0]         accept_w;
  logic [NBANK-1:0]         done_w;
  logic [NBANK-1:0]         tog_w;
  logic [NBANK-1:0]         hit_w;
  logic [NBANK-1:0][DW-1:0] stat_w;
  wop_e                     op_w;

  assign op_w = wop_e'(op_i);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    flash_wstat_timer #(
      .DW(DW), .CW(CW),
      .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC),
      .BLK_CYC(BLK_CYC), .BANK_CYC(BANK_CYC)
    ) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i[b]),
      .op_i     (op_w),
      .word_i   (word_i),
      .rd_hit_i (hit_w[b]),
      .busy_o   (busy_w[b]),
      .accept_o (accept_w[b]),
      .done_o   (done_w[b]),
      .tog_o    (tog_w[b]),
      .stat_o   (stat_w[b])
    );
  end

  flash_wstat_rdport #(.NBANK(NBANK), .DW(DW), .BSW(BSW)) i_rdport (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_stb_i  (rd_stb_i),
    .rd_bank_i (rd_bank_i),
    .busy_i    (busy_w),
    .stat_i    (stat_w),
    .arr_i     (arr_data_i),
    .hit_o     (hit_w),
    .rd_data_o (rd_data_o)
  );

  assign rb_low_o = |busy_w;

endmodule

// File: rtl/flash_wstat_chk.sv
module flash_wstat_chk #(
  parameter int unsigned NBANK = 2,
  parameter int unsigned DW    = 16,
  parameter int unsigned BSW   = 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NBANK-1:0]         start_i,
  input logic [DW-1:0]            word_i,
  input logic                     rd_stb_i,
  input logic [BSW-1:0]           rd_bank_i,
  input logic [DW-1:0]            arr_data_i,
  input logic [DW-1:0]            rd_data_o,
  input logic                     rb_low_o,
  input logic [NBANK-1:0]         busy_w,
  input logic [NBANK-1:0]         accept_w,
  input logic [NBANK-1:0]         done_w,
  input logic [NBANK-1:0]         tog_w,
  input logic [NBANK-1:0][DW-1:0] stat_w
);

  for (genvar b = 0; b < NBANK; b++) begin : g_b
    a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      accept_w[b] |=> busy_w[b]);

    a_r6_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_w[b] && !done_w[b]) |=> busy_w[b]);

    a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i[b] && busy_w[b] && !(rd_stb_i && rd_bank_i == BSW'(b))) |=> $stable(stat_w[b]));

    a_r4_poll_inverted: assert property (@(posedge clk) disable iff (!rst_n)
      accept_w[b] |=> (stat_w[b][7] == !$past(word_i[7])));

    a_r3_toggle_clear: assert property (@(posedge clk) disable iff (!rst_n)
      accept_w[b] |=> !tog_w[b]);

    a_r3_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb_i && rd_bank_i == BSW'(b) && busy_w[b]) |=> (tog_w[b] != $past(tog_w[b])));

    a_r8_toggle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_w[b] && !accept_w[b]) |=> $stable(tog_w[b]));

    a_r4_status_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb_i && rd_bank_i == BSW'(b) && busy_w[b]) |=> (rd_data_o == $past(stat_w[b])));
  end

  a_r7_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && !busy_w[rd_bank_i]) |=> (rd_data_o == $past(arr_data_i)));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb_i |=> $stable(rd_data_o));

  a_r5_rb_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rb_low_o) |-> $past(|accept_w));

endmodule

bind flash_wstat flash_wstat_chk #(.NBANK(NBANK), .DW(DW), .BSW(BSW)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .word_i     (word_i),
  .rd_stb_i   (rd_stb_i),
  .rd_bank_i  (rd_bank_i),
  .arr_data_i (arr_data_i),
  .rd_data_o  (rd_data_o),
  .rb_low_o   (rb_low_o),
  .busy_w     (busy_w),
  .accept_w   (accept_w),
  .done_w     (done_w),
  .tog_w      (tog_w),
  .stat_w     (stat_w)
);

// File: tb/test_flash_wstat.sv
module test_flash_wstat;

  localparam int P = 5, S = 9, B = 11, K = 24;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  start_i;
  logic [1:0]  op_i;
  logic [15:0] word_i;
  logic        rd_stb_i;
  logic [0:0]  rd_bank_i;
  logic [15:0] arr_data_i;
  logic [15:0] rd_data_o;
  logic        rb_low_o;

  always #5 clk = ~clk;

  flash_wstat #(.NBANK(2), .DW(16), .PROG_CYC(P), .SECT_CYC(S),
                .BLK_CYC(B), .BANK_CYC(K)) i_flash_wstat (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .word_i(word_i),
    .rd_stb_i(rd_stb_i), .rd_bank_i(rd_bank_i), .arr_data_i(arr_data_i),
    .rd_data_o(rd_data_o), .rb_low_o(rb_low_o));

  int vectors = 0, fails = 0, busy_seen = 0;
  bit finished = 0;

  // bench model of each bank
  int          rem [2];
  logic        tog [2];
  logic [15:0] wq  [2];
  logic [15:0] exp_d = '0;

  // scoreboard queues
  logic [15:0] q_d  [$];
  logic        q_rb [$];
  string       q_tag[$];

  function automatic int dur(input logic [1:0] op);
    case (op)
      2'd0: return P;
      2'd1: return S;
      2'd2: return B;
      default: return K;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the expected result
  task automatic step(input logic [1:0] st, input logic [1:0] op, input logic [15:0] wd,
                      input logic rd, input logic bk, input logic [15:0] arr, input string tag);
    start_i = st; op_i = op; word_i = wd; rd_stb_i = rd; rd_bank_i = bk; arr_data_i = arr;
    @(posedge clk);
    if (rd) begin
      if (rem[bk] != 0) begin
        exp_d   = {wq[bk][15:8], ~wq[bk][7], tog[bk], wq[bk][5:0]};
        tog[bk] = ~tog[bk];
      end else exp_d = arr;
    end
    for (int b = 0; b < 2; b++) begin
      if (st[b] && rem[b] == 0) begin
        rem[b] = dur(op); wq[b] = wd; tog[b] = 1'b0;
      end else if (rem[b] > 0) rem[b]--;
    end
    q_d.push_back(exp_d);
    q_rb.push_back(rem[0] != 0 || rem[1] != 0);
    q_tag.push_back(tag);
    @(negedge clk);
    if (rb_low_o) busy_seen++;
  endtask

  task automatic idle_till_done();
    while (rem[0] != 0 || rem[1] != 0) step(2'b00, 2'd0, 16'h0, 1'b0, 1'b0, 16'h0, "R9");
  endtask

  // monitor: compares the design's outputs against the queued expectations
  always @(negedge clk) begin
    if (q_d.size() > 0) begin
      logic [15:0] d;
      logic        rb;
      string       t;
      d = q_d.pop_front(); rb = q_rb.pop_front(); t = q_tag.pop_front();
      vectors++;
      if (rd_data_o !== d) begin
        fails++;
        $display("FAIL %s rd_data act=%h exp=%h", t, rd_data_o, d);
      end
      vectors++;
      if (rb_low_o !== rb) begin
        fails++;
        $display("FAIL R5 rb_low act=%b exp=%b", rb_low_o, rb);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++) begin rem[b] = 0; tog[b] = 1'b0; wq[b] = '0; end
    rst_n = 1'b0; start_i = '0; op_i = '0; word_i = '0; rd_stb_i = 1'b0;
    rd_bank_i = '0; arr_data_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rd_data_o == 16'h0, "R1", rd_data_o, 0);   // R1 reset state
    chk(rb_low_o == 1'b0, "R1", rb_low_o, 0);
    rst_n = 1'b1;

    // R7 idle reads pass array data; R9 hold
    step(2'b00, 2'd0, 16'h0, 1'b1, 1'b0, 16'h1234, "R7");
    step(2'b00, 2'd0, 16'h0, 1'b1, 1'b1, 16'hBEEF, "R7");
    step(2'b00, 2'd0, 16'h0, 1'b0, 1'b0, 16'h7777, "R9");

    // R2 program on bank 0, R3/R4 status reads, R7 concurrent read of bank 1
    busy_seen = 0;
    step(2'b01, 2'd0, 16'h00A5, 1'b0, 1'b0, 16'h0, "R2");
    step(2'b00, 2'd0, 16'h0, 1'b1, 1'b0, 16'hFFFF, "R4");
    step(2'b00, 2'd0, 16'h0, 1'b1, 1'b0, 16'hFFFF, "R3");
    step(2'b00, 2'd0, 16'h0, 1'b1, 1'b0, 16'hFFFF, "R3");
    step(2'b00, 2'd0, 16'h0, 1'b1, 1'b1, 16'h5A5A, "R7");
    idle_till_done();
    chk(busy_seen == P, "R2", busy_seen, P);

    // R8 two confirming reads after completion
    step(2'b00, 2'd0, 16'h0, 1'b1, 1'b0, 16'h0F0F, "R8");
    step(2'b00, 2'd0, 16'h0, 1'b1, 1'b0, 16'h0F0F, "R8");
    chk(rd_data_o == 16'h0F0F, "R8", rd_data_o, 16'h0F0F);

    // R6 start to busy bank 1 is ignored
    busy_seen = 0;
    step(2'b10, 2'd1, 16'h0000, 1'b0, 1'b0, 16'h0, "R2");
    step(2'b00, 2'd0, 16'h0, 1'b0, 1'b0, 16'h0, "R9");
    step(2'b10, 2'd3, 16'hFF80, 1'b1, 1'b1, 16'h3333, "R6");
    chk(rd_data_o[7] == 1'b1, "R6", rd_data_o[7], 1);
    idle_till_done();
    chk(busy_seen == S, "R6", busy_seen, S);

    // R10 overlapping cycles of different length; R3 toggle restarts at 0
    busy_seen = 0;
    step(2'b01, 2'd2, 16'h8001, 1'b0, 1'b0, 16'h0, "R2");
    step(2'b10, 2'd3, 16'h7F00, 1'b1, 1'b0, 16'hAAAA, "R3");
    chk(rd_data_o[6] == 1'b0, "R3", rd_data_o[6], 0);
    step(2'b00, 2'd0, 16'h0, 1'b1, 1'b0, 16'hAAAA, "R3");
    step(2'b00, 2'd0, 16'h0, 1'b1, 1'b1, 16'hAAAA, "R4");
    idle_till_done();
    chk(busy_seen == K + 1, "R10", busy_seen, K + 1);

    // R7 start and read of an idle bank in the same cycle
    step(2'b01, 2'd0, 16'h1111, 1'b1, 1'b0, 16'h2222, "R7");
    chk(rd_data_o == 16'h2222, "R7", rd_data_o, 16'h2222);
    idle_till_done();
    step(2'b00, 2'd0, 16'h0, 1'b0, 1'b0, 16'h0, "R9");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule